// File: doc/BRIEF.md
# Shared-Converter Macropixel Controller

This block is the digital controller for a macropixel: a cluster of four photon detectors that share a single time-to-digital converter. Each detector pulse arrives already synchronised to the clock and lasts one cycle per detection. Every detector has its own event counter. The counters keep running no matter which detector wins the converter. Inside each gate window, an arbiter chooses at most one detection to be timed. It raises a one-cycle converter request that carries the index of the winning detector.

The arbiter has two modes, chosen by a mode pin:

- **Single-photon mode.** The first detection in the window wins. Its detector index is kept, so spatial resolution is preserved.
- **Coincidence mode.** A conversion starts only when a second, different detector fires within a programmable number of cycles after an opening detection. Isolated background hits therefore produce no timing result.

A coarse cycle counter stands in for the converter's timestamp. It counts from the first cycle of each gate.

When each gate closes, the block emits one result item on a valid/ready stream. The item carries a hit flag, the detector index, a 12-bit code and the window number. Back-pressure rule: an item is held unchanged until it is accepted. If a window closes while the previous item is still waiting, the new item is discarded and the window number still advances. A frame holds at most 62 windows. A frame-start strobe clears the counters and the window numbering.

Top module: `mpx_tdc_share_ctrl`

## Requirements
- R1: There are four 8-bit event counters, all zero after reset. Counter k sits at `cnt_o[8k+7:8k]`. It increases by one in each clock cycle in which `det_i[k]` and `gate_i` are both high, whatever the arbitration does, and the new value is visible the cycle after.
- R2: Each event counter saturates at 255 and never wraps.
- R3: A cycle with `frame_start_i` high sets all counters to zero at the next cycle. It also restarts window numbering at 1.
- R4: Detections while `gate_i` is low change no counter, raise no converter request and produce no result item.
- R5: In single-photon mode (`coinc_mode_i`=0), the first cycle with any detection wins. If several detectors fire in that cycle, the lowest index wins. At most one conversion happens per gate.
- R6: In coincidence mode (`coinc_mode_i`=1), a detection opens a window of `coinc_win_i` cycles. A different detector firing 0 to `coinc_win_i` cycles after the opener completes the coincidence, and the lowest such index is reported. Repeats of the opening detector are not counted. Once the window has expired, the next detection opens a new window. If no coincidence completes, the gate gives no hit.
- R7: The timing code is the number of cycles from the first high cycle of the gate to the winning detection (0 for a win in that first cycle). It saturates at 4095. In coincidence mode it is taken at the completing detection.
- R8: `conv_req_o` is a one-cycle pulse in the cycle after the winning detection, with `conv_sel_o` giving the winner index.
- R9: In the cycle after `gate_i` falls, a result item appears on `res_*`. When there was no conversion, `res_hit_o`=0 and both `res_idx_o` and `res_code_o` are zero.
- R10: `res_win_o` numbers the windows of a frame from 1. After the 62nd window of a frame, gates produce no converter request and no item until the next frame start.
- R11: While `res_valid_o` is high and `res_ready_i` is low, the item stays unchanged. An item produced while the slot is still full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_i | input | 1 | Gate enable; high while a window is open |
| frame_start_i | input | 1 | Frame-start strobe |
| det_i | input | 4 | Synchronised detector pulses |
| coinc_mode_i | input | 1 | 0 single-photon, 1 coincidence |
| coinc_win_i | input | 4 | Coincidence window in cycles |
| cnt_o | output | 32 | Four packed 8-bit event counts |
| conv_req_o | output | 1 | Converter start request pulse |
| conv_sel_o | output | 2 | Index of detector granted the converter |
| res_valid_o | output | 1 | Result item valid |
| res_ready_i | input | 1 | Result item accepted |
| res_hit_o | output | 1 | Item holds a conversion |
| res_idx_o | output | 2 | Detector index of the conversion |
| res_code_o | output | 12 | Timing code |
| res_win_o | output | 6 | Window number within the frame |

## Verification
Single-photon mode is driven with a lone detection, a later detection after a win, and a two-detector tie. These separate first-come order from lowest-index priority and show that only one conversion happens per gate. Coincidence mode is driven with four patterns:

- a same-detector repeat followed by a partner at exactly the window limit;
- a partner arriving too late, which re-opens the window and then completes with a third detector;
- two detectors firing in the same cycle;
- repeats of one detector only.

Together these tell the inclusive window limit, expiry and re-open, and the rule that a coincidence needs two distinct detectors. Further runs cover detections with the gate low, a 300-cycle saturation gate, a stalled result slot, and the 63rd window of a frame.

// File: rtl/mpx_pkg.sv
`timescale 1ns/1ps
package mpx_pkg;
  localparam int NDET  = 4;
  localparam int IDX_W = $clog2(NDET);

  typedef enum logic {MODE_SINGLE = 1'b0, MODE_COINC = 1'b1} arb_mode_e;

  // lowest set position; zero when the vector is empty
  function automatic logic [IDX_W-1:0] low_idx(input logic [NDET-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NDET - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/mpx_event_counters.sv
`timescale 1ns/1ps
module mpx_event_counters #(
  parameter int NDET  = 4,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic [NDET-1:0]       hit,
  output logic [NDET*CNT_W-1:0] cnt
);
  for (genvar k = 0; k < NDET; k++) begin : g_cnt
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     c_q <= '0;
      else if (clr)                   c_q <= '0;
      else if (hit[k] && c_q != '1)   c_q <= c_q + 1'b1;
    end
    assign cnt[k*CNT_W +: CNT_W] = c_q;
  end
endmodule

// File: rtl/mpx_timebase.sv
`timescale 1ns/1ps
module mpx_timebase #(
  parameter int CODE_W  = 12,
  parameter int MAX_WIN = 62,
  parameter int WIN_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate,
  input  logic              frame_start,
  output logic [CODE_W-1:0] tcnt,
  output logic              gate_fall,
  output logic              arm_ok,
  output logic [WIN_W-1:0]  win_cur
);
  logic             gate_q;
  logic [WIN_W-1:0] done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      tcnt   <= '0;
      done_q <= '0;
    end else begin
      gate_q <= gate;
      if (!gate)            tcnt <= '0;
      else if (tcnt != '1)  tcnt <= tcnt + 1'b1;
      if (frame_start)                done_q <= '0;
      else if (gate_fall && arm_ok)   done_q <= done_q + 1'b1;
    end
  end

  assign gate_fall = gate_q && !gate;
  assign arm_ok    = done_q < WIN_W'(MAX_WIN);
  assign win_cur   = done_q + 1'b1;
endmodule

// File: rtl/mpx_arbiter.sv
`timescale 1ns/1ps
module mpx_arbiter
  import mpx_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int CW_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [NDET-1:0]   det,
  input  arb_mode_e         mode,
  input  logic [CW_W-1:0]   cw,
  input  logic [CODE_W-1:0] tcnt,
  output logic              done,
  output logic [IDX_W-1:0]  idx,
  output logic [CODE_W-1:0] code,
  output logic              req,
  output logic [IDX_W-1:0]  req_idx
);
  logic              open_q;
  logic [NDET-1:0]   first_q;
  logic [CW_W:0]     wcnt_q;

  logic              open_ok, win_now, nxt_open;
  logic [IDX_W-1:0]  win_sel, opener;
  logic [NDET-1:0]   partners, rest, op_oh, nxt_first;
  logic [CW_W:0]     nxt_wcnt;

  always_comb begin
    open_ok   = open_q && (wcnt_q <= {1'b0, cw});
    partners  = det & ~first_q;
    opener    = low_idx(det);
    op_oh     = NDET'(1) << opener;
    rest      = det & ~op_oh;
    win_now   = 1'b0;
    win_sel   = '0;
    nxt_open  = open_q;
    nxt_first = first_q;
    nxt_wcnt  = (open_q && wcnt_q != '1) ? wcnt_q + 1'b1 : wcnt_q;
    if (en && !done) begin
      if (mode == MODE_SINGLE) begin
        win_now = |det;
        win_sel = opener;
      end else if (open_ok && |partners) begin
        win_now = 1'b1;
        win_sel = low_idx(partners);
      end else if (!open_ok && |det) begin
        if (|rest) begin
          win_now = 1'b1;
          win_sel = low_idx(rest);
        end else begin
          nxt_open  = 1'b1;
          nxt_first = op_oh;
          nxt_wcnt  = 1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; idx <= '0; code <= '0;
      open_q <= 1'b0; first_q <= '0; wcnt_q <= '0;
      req <= 1'b0; req_idx <= '0;
    end else begin
      req     <= win_now;
      req_idx <= win_sel;
      if (!en) begin
        done <= 1'b0; idx <= '0; code <= '0;
        open_q <= 1'b0; first_q <= '0; wcnt_q <= '0;
      end else begin
        if (win_now) begin
          done <= 1'b1;
          idx  <= win_sel;
          code <= tcnt;
        end
        open_q  <= nxt_open;
        first_q <= nxt_first;
        wcnt_q  <= nxt_wcnt;
      end
    end
  end
endmodule

// File: rtl/mpx_result_slot.sv
`timescale 1ns/1ps
module mpx_result_slot #(
  parameter int IDX_W  = 2,
  parameter int CODE_W = 12,
  parameter int WIN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              l_hit,
  input  logic [IDX_W-1:0]  l_idx,
  input  logic [CODE_W-1:0] l_code,
  input  logic [WIN_W-1:0]  l_win,
  input  logic              ready,
  output logic              valid,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [CODE_W-1:0] code,
  output logic [WIN_W-1:0]  win
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0; hit <= 1'b0; idx <= '0; code <= '0; win <= '0;
    end else if (load && (!valid || ready)) begin
      valid <= 1'b1;
      hit   <= l_hit;
      idx   <= l_hit ? l_idx : '0;
      code  <= l_hit ? l_code : '0;
      win   <= l_win;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mpx_tdc_share_ctrl.sv
`timescale 1ns/1ps
module mpx_tdc_share_ctrl
  import mpx_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int CODE_W  = 12,
  parameter int CW_W    = 4,
  parameter int MAX_WIN = 62,
  localparam int WIN_W  = $clog2(MAX_WIN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  gate_i,
  input  logic                  frame_start_i,
  input  logic [NDET-1:0]       det_i,
  input  logic                  coinc_mode_i,
  input  logic [CW_W-1:0]       coinc_win_i,
  output logic [NDET*CNT_W-1:0] cnt_o,
  output logic                  conv_req_o,
  output logic [IDX_W-1:0]      conv_sel_o,
  output logic                  res_valid_o,
  input  logic                  res_ready_i,
  output logic                  res_hit_o,
  output logic [IDX_W-1:0]      res_idx_o,
  output logic [CODE_W-1:0]     res_code_o,
  output logic [WIN_W-1:0]      res_win_o
);
  logic [NDET-1:0]   det_g;
  logic [CODE_W-1:0] tcnt;
  logic              gate_fall, arm_ok, a_done;
  logic [WIN_W-1:0]  win_cur;
  logic [IDX_W-1:0]  a_idx;
  logic [CODE_W-1:0] a_code;

  assign det_g = det_i & {NDET{gate_i}};

  mpx_event_counters #(.NDET(NDET), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(frame_start_i), .hit(det_g), .cnt(cnt_o)
  );

  mpx_timebase #(.CODE_W(CODE_W), .MAX_WIN(MAX_WIN), .WIN_W(WIN_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .gate(gate_i), .frame_start(frame_start_i),
    .tcnt(tcnt), .gate_fall(gate_fall), .arm_ok(arm_ok), .win_cur(win_cur)
  );

  mpx_arbiter #(.CODE_W(CODE_W), .CW_W(CW_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .en(gate_i && arm_ok), .det(det_g),
    .mode(arb_mode_e'(coinc_mode_i)), .cw(coinc_win_i), .tcnt(tcnt),
    .done(a_done), .idx(a_idx), .code(a_code),
    .req(conv_req_o), .req_idx(conv_sel_o)
  );

  mpx_result_slot #(.IDX_W(IDX_W), .CODE_W(CODE_W), .WIN_W(WIN_W)) u_res (
    .clk(clk), .rst_n(rst_n), .load(gate_fall && arm_ok),
    .l_hit(a_done), .l_idx(a_idx), .l_code(a_code), .l_win(win_cur),
    .ready(res_ready_i), .valid(res_valid_o), .hit(res_hit_o),
    .idx(res_idx_o), .code(res_code_o), .win(res_win_o)
  );
endmodule

// File: rtl/mpx_tdc_share_chk.sv
`timescale 1ns/1ps
module mpx_tdc_share_chk #(
  parameter int NDET    = 4,
  parameter int IDX_W   = 2,
  parameter int CNT_W   = 8,
  parameter int CODE_W  = 12,
  parameter int MAX_WIN = 62,
  parameter int WIN_W   = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  gate_i,
  input logic                  frame_start_i,
  input logic [NDET*CNT_W-1:0] cnt_o,
  input logic                  conv_req_o,
  input logic                  res_valid_o,
  input logic                  res_ready_i,
  input logic                  res_hit_o,
  input logic [IDX_W-1:0]      res_idx_o,
  input logic [CODE_W-1:0]     res_code_o,
  input logic [WIN_W-1:0]      res_win_o
);
  // R8
  conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_o |=> !conv_req_o);

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_hit_o) &&
      $stable(res_idx_o) && $stable(res_code_o) && $stable(res_win_o)));

  // R4
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_i && !frame_start_i) |=> $stable(cnt_o));

  // R3
  frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (cnt_o == '0));

  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_hit_o) |-> (res_code_o == '0 && res_idx_o == '0));

  // R10
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (res_win_o >= WIN_W'(1) && res_win_o <= WIN_W'(MAX_WIN)));

  for (genvar k = 0; k < NDET; k++) begin : g_mono
    // R2
    cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start_i |=> (cnt_o[k*CNT_W +: CNT_W] >= $past(cnt_o[k*CNT_W +: CNT_W])));
  end
endmodule

bind mpx_tdc_share_ctrl mpx_tdc_share_chk #(
  .NDET(mpx_pkg::NDET), .IDX_W(mpx_pkg::IDX_W), .CNT_W(CNT_W),
  .CODE_W(CODE_W), .MAX_WIN(MAX_WIN), .WIN_W(WIN_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .frame_start_i(frame_start_i),
  .cnt_o(cnt_o), .conv_req_o(conv_req_o), .res_valid_o(res_valid_o),
  .res_ready_i(res_ready_i), .res_hit_o(res_hit_o), .res_idx_o(res_idx_o),
  .res_code_o(res_code_o), .res_win_o(res_win_o)
);

// File: tb/mpx_tdc_share_ctrl_tb_top.sv
`timescale 1ns/1ps
module mpx_tdc_share_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate = 1'b0, fs = 1'b0, mode = 1'b0, ready = 1'b1;
  logic [3:0]  det = '0, cw = '0;
  logic [31:0] cnt;
  logic        conv_req, res_valid, res_hit;
  logic [1:0]  conv_sel, res_idx;
  logic [11:0] res_code;
  logic [5:0]  res_win;

  typedef struct packed {
    logic hit; logic [1:0] idx; logic [11:0] code; logic [5:0] win;
  } item_t;

  item_t exp_q[$];
  int    n_chk = 0, n_fail = 0;
  int    exp_cnt[4];
  int    wins = 0;
  int    conv_seen = 0;
  logic [1:0] conv_last = '0;

  always #2.5 clk = ~clk;

  mpx_tdc_share_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .gate_i(gate), .frame_start_i(fs), .det_i(det),
    .coinc_mode_i(mode), .coinc_win_i(cw), .cnt_o(cnt), .conv_req_o(conv_req),
    .conv_sel_o(conv_sel), .res_valid_o(res_valid), .res_ready_i(ready),
    .res_hit_o(res_hit), .res_idx_o(res_idx), .res_code_o(res_code), .res_win_o(res_win)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic chk_counts(input string req);
    for (int k = 0; k < 4; k++)
      chk(int'(cnt[k*8 +: 8]) == exp_cnt[k], req, $sformatf("count %0d", k),
          int'(cnt[k*8 +: 8]), exp_cnt[k]);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_req) begin
        conv_seen++;
        conv_last = conv_sel;
      end
      if (res_valid && ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected item win", int'(res_win), 0);
        end else begin
          item_t e;
          item_t a;
          e = exp_q.pop_front();
          a = '{hit: res_hit, idx: res_idx, code: res_code, win: res_win};
          chk(a == e, "R9", $sformatf("item hit/idx/code/win %0d/%0d/%0d/%0d vs",
              a.hit, a.idx, a.code, a.win), int'(a), int'(e));
        end
      end
    end
  end

  task automatic frame();
    @(posedge clk); #1 fs = 1'b1;
    @(posedge clk); #1 fs = 1'b0;
    for (int k = 0; k < 4; k++) exp_cnt[k] = 0;
    wins = 0;
  endtask

  // driver: one gate window of len cycles; nibble j of pats drives cycle j,
  // tailp drives every cycle from 16 on
  task automatic run_win(input int len, input logic [63:0] pats, input logic [3:0] tailp,
                         input bit eh, input logic [1:0] ei, input int ec,
                         input bit push, input string req);
    bit armed;
    armed = (wins < 62);
    conv_seen = 0;
    for (int j = 0; j < len; j++) begin
      @(posedge clk); #1;
      gate = 1'b1;
      det  = (j < 16) ? pats[4*j +: 4] : tailp;
      for (int k = 0; k < 4; k++)
        if (det[k] && exp_cnt[k] < 255) exp_cnt[k]++;
    end
    @(posedge clk); #1;
    gate = 1'b0; det = '0;
    if (armed) begin
      wins++;
      if (push) exp_q.push_back('{hit: eh, idx: eh ? ei : 2'd0,
                                  code: eh ? 12'(ec) : 12'd0, win: 6'(wins)});
    end
    repeat (3) @(posedge clk);
    #1;
    chk(conv_seen == ((eh && armed) ? 1 : 0), req, "conversion count",
        conv_seen, (eh && armed) ? 1 : 0);
    if (eh && armed) chk(conv_last == ei, req, "conv_sel", int'(conv_last), int'(ei));
    chk_counts("R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not end", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) exp_cnt[k] = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cnt == '0, "R1", "counts after reset", int'(cnt), 0);
    chk(!res_valid && !conv_req, "R9", "outputs idle after reset", int'(res_valid), 0);
    frame();

    // R5 single-photon: later detection loses, tie goes to lowest index
    mode = 1'b0;
    run_win(6, 64'h1400, 4'h0, 1'b1, 2'd2, 2, 1'b1, "R5");
    run_win(4, 64'h00A0, 4'h0, 1'b1, 2'd1, 1, 1'b1, "R5");
    run_win(4, 64'h0,    4'h0, 1'b0, 2'd0, 0, 1'b1, "R9");

    // R6 coincidence: repeat ignored, partner at exactly the limit (R7 code)
    mode = 1'b1; cw = 4'd3;
    run_win(6, 64'h8101, 4'h0, 1'b1, 2'd3, 3, 1'b1, "R6");
    // R6 expiry then re-open, completion by a third detector
    cw = 4'd2;
    run_win(8, 64'h104002, 4'h0, 1'b1, 2'd0, 5, 1'b1, "R6");
    // R6 simultaneous pair
    cw = 4'd5;
    run_win(4, 64'h60, 4'h0, 1'b1, 2'd2, 1, 1'b1, "R6");
    // R6 partner too late, no hit
    cw = 4'd1;
    run_win(6, 64'h2001, 4'h0, 1'b0, 2'd0, 0, 1'b1, "R6");
    // R6 one detector repeating only
    cw = 4'd15;
    run_win(5, 64'h111, 4'h0, 1'b0, 2'd0, 0, 1'b1, "R6");

    // R4 detections with gate low
    conv_seen = 0;
    @(posedge clk); #1 det = 4'hF;
    repeat (5) @(posedge clk);
    #1 det = 4'h0;
    repeat (2) @(posedge clk);
    #1;
    chk_counts("R4");
    chk(conv_seen == 0, "R4", "request with gate low", conv_seen, 0);
    chk(!res_valid, "R4", "item with gate low", int'(res_valid), 0);
    mode = 1'b0;
    run_win(5, 64'h2000, 4'h0, 1'b1, 2'd1, 3, 1'b1, "R7");

    // R2 saturation over a long gate
    run_win(300, 64'h1111_1111_1111_1111, 4'h1, 1'b1, 2'd0, 0, 1'b1, "R2");
    chk(int'(cnt[7:0]) == 255, "R2", "saturated count", int'(cnt[7:0]), 255);

    // R3 frame start clears counters
    frame();
    chk(cnt == '0, "R3", "counts after frame start", int'(cnt), 0);

    // R11 back-pressure: first item held, second dropped
    ready = 1'b0;
    run_win(3, 64'h40, 4'h0, 1'b1, 2'd2, 1, 1'b1, "R11");
    run_win(3, 64'h1,  4'h0, 1'b1, 2'd0, 0, 1'b0, "R11");
    @(negedge clk);
    chk(res_valid == 1'b1, "R11", "item held", int'(res_valid), 1);
    chk(res_win == 6'd1 && res_idx == 2'd2, "R11", "held window", int'(res_win), 1);
    @(posedge clk); #1 ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R11", "pending items", exp_q.size(), 0);

    // R10 window limit: fill the frame, then a 63rd gate yields nothing
    frame();
    for (int w = 0; w < 62; w++) run_win(2, 64'h0, 4'h0, 1'b0, 2'd0, 0, 1'b1, "R10");
    run_win(3, 64'h1, 4'h0, 1'b1, 2'd0, 0, 1'b1, "R10");
    chk(exp_q.size() == 0, "R10", "items after limit", exp_q.size(), 0);
    frame();
    run_win(3, 64'h20, 4'h0, 1'b1, 2'd1, 1, 1'b1, "R10");

    repeat (5) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R9", "items never produced", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule